// File: doc/BRIEF.md
# Quad DAC Serial Command Front End

This block is the digital command interface of a four-channel, 12-bit voltage-output converter. A host shifts 16-bit words in over a three-wire serial link made of an active-low select, a serial clock and a data line. Each word names a channel, a control code and a 12-bit value. Every channel has two register stages. The first is an input register that the host writes. The second is a converter register whose value drives the analog side. A hold input chooses whether the converter registers follow their input registers or keep their value.

A serial data output passes the previous word on, one bit per clock, so devices can be chained. A mode command picks the serial clock edge on which that output changes. The serial pins are oversampled by the block's system clock. Each pin goes through a two-stage synchronizer, and edges are detected after that.

Top module: `quad_dac_front`

## Requirements
- R1: While `csN` is low, each rising `sck` edge shifts `sdi` into a 16-bit register, most significant bit first. The word acts once, at the rising edge of `csN`. In the word, bits 15:14 are the channel (00 = channel 0 in `dacOut[11:0]`, up to 11 = channel 3 in `dacOut[47:36]`), bits 13:12 are the control code, and bits 11:0 are the data.
- R2: A frame with fewer than 16 rising clocks changes no register. A frame with more than 16 acts on the last 16 bits shifted in.
- R3: Control code 00 writes the data to the addressed input register only. While `holdDac` is high, the converter outputs do not change.
- R4: Control code 01 writes the addressed input register and copies it into that channel's converter register. The other channels are untouched.
- R5: Control code 10 writes the addressed input register, then copies all four input registers into the converter registers.
- R6: With control code 11, channel field 01 copies all input registers to the converter registers. Channel field 00 is a no-operation that changes nothing.
- R7: Control code 11 with channel field 10 writes the data into all four input registers and all four converter registers.
- R8: Control code 11 with channel field 11 is the mode command. Data bit 11 = 1 selects rising-edge output and 0 selects falling-edge output. The mode command also copies all input registers to the converter registers.
- R9: While `holdDac` is low, each converter register follows its input register within one system clock.
- R10: Reset clears every register to zero and `sdo` to 0, and selects rising-edge output mode.
- R11: `sdo` presents the word previously held in the shift register, most significant bit first. In rising mode it updates on each rising `sck` edge. In falling mode it updates at the `csN` fall and on each falling `sck` edge, so each bit is stable before the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Active-low frame select |
| sck | input | 1 | Serial clock |
| sdi | input | 1 | Serial data in |
| holdDac | input | 1 | High: converter registers hold; low: they follow the input registers |
| sdo | output | 1 | Serial data out for chaining |
| dacOut | output | 48 | Four 12-bit converter register values, channel 0 in the low bits |

## Verification
The input registers cannot be seen at the ports. A load-only command therefore shows nothing until the value is made visible in some other way. The stimulus loads channels with hold high and checks that the outputs stay put. It then exposes the stored values, either with an update command or by dropping the hold. The falling-edge output mode is also hard to observe, because it differs from the default by only half a serial clock. The bench sends the mode command and two further words, samples `sdo` just before every rising edge, and compares the result with the word sent before.

// File: rtl/qdac_pkg.sv
package qdac_pkg;
  parameter int unsigned NUM_CH = 4;
  parameter int unsigned DATA_W = 12;
  parameter int unsigned ADDR_W = 2;
  parameter int unsigned CTL_W  = 2;
  localparam int unsigned WORD_W = ADDR_W + CTL_W + DATA_W;
  localparam int unsigned CNT_W  = $clog2(WORD_W + 1);

  typedef enum logic [CTL_W-1:0] {
    CTL_LOAD     = 2'b00,
    CTL_LOAD_UPD = 2'b01,
    CTL_LOAD_ALL = 2'b10,
    CTL_SPECIAL  = 2'b11
  } ctl_e;

  typedef enum logic [ADDR_W-1:0] {
    SP_NOP       = 2'b00,
    SP_UPDATE    = 2'b01,
    SP_BROADCAST = 2'b10,
    SP_MODE      = 2'b11
  } special_e;

  typedef struct packed {
    logic              loadOne;
    logic              updOne;
    logic              updAll;
    logic              loadAll;
    logic [NUM_CH-1:0] chanSel;
    logic [DATA_W-1:0] data;
  } strobe_t;
endpackage

// File: rtl/qdac_sync.sv
module qdac_sync #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);
  logic meta;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      meta <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/qdac_serial_ctrl.sv
module qdac_serial_ctrl
  import qdac_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    csN,
  input  logic    sck,
  input  logic    sdi,
  output logic    sdo,
  output strobe_t stb
);
  logic csS, sckS, sdiS;
  logic csPrev, sckPrev;
  logic sckRise, sckFall, csFall, csRise;
  logic [WORD_W-1:0] shReg;
  logic [CNT_W-1:0]  bitCnt;
  logic modeRise;
  logic sdoReg;
  logic fire;
  strobe_t stbNext;
  logic modeNext;

  logic [ADDR_W-1:0] wAddr;
  logic [CTL_W-1:0]  wCtl;
  logic [DATA_W-1:0] wData;

  qdac_sync #(.RST_VAL(1'b1)) csSync_i  (.clk(clk), .rstN(rstN), .d(csN), .q(csS));
  qdac_sync #(.RST_VAL(1'b0)) sckSync_i (.clk(clk), .rstN(rstN), .d(sck), .q(sckS));
  qdac_sync #(.RST_VAL(1'b0)) sdiSync_i (.clk(clk), .rstN(rstN), .d(sdi), .q(sdiS));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csPrev  <= 1'b1;
      sckPrev <= 1'b0;
    end else begin
      csPrev  <= csS;
      sckPrev <= sckS;
    end
  end

  assign sckRise = !csS && sckS && !sckPrev;
  assign sckFall = !csS && !sckS && sckPrev;
  assign csFall  = !csS && csPrev;
  assign csRise  = csS && !csPrev;

  // bit counter saturates at a full word; shift register keeps the last bits
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt <= '0;
      shReg  <= '0;
    end else begin
      if (csFall) bitCnt <= '0;
      else if (sckRise && bitCnt != CNT_W'(WORD_W)) bitCnt <= bitCnt + 1'b1;
      if (sckRise) shReg <= {shReg[WORD_W-2:0], sdiS};
    end
  end

  // chained output: edge chosen by mode
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sdoReg <= 1'b0;
    end else if (modeRise && sckRise) begin
      sdoReg <= shReg[WORD_W-1];
    end else if (!modeRise && (sckFall || csFall)) begin
      sdoReg <= shReg[WORD_W-1];
    end
  end
  assign sdo = sdoReg;

  assign wAddr = shReg[WORD_W-1 -: ADDR_W];
  assign wCtl  = shReg[DATA_W +: CTL_W];
  assign wData = shReg[DATA_W-1:0];
  assign fire  = csRise && (bitCnt == CNT_W'(WORD_W));

  always_comb begin
    stbNext      = '0;
    stbNext.data = wData;
    modeNext     = modeRise;
    if (fire) begin
      unique case (ctl_e'(wCtl))
        CTL_LOAD: begin
          stbNext.loadOne = 1'b1;
          stbNext.chanSel = NUM_CH'(1) << wAddr;
        end
        CTL_LOAD_UPD: begin
          stbNext.loadOne = 1'b1;
          stbNext.updOne  = 1'b1;
          stbNext.chanSel = NUM_CH'(1) << wAddr;
        end
        CTL_LOAD_ALL: begin
          stbNext.loadOne = 1'b1;
          stbNext.updAll  = 1'b1;
          stbNext.chanSel = NUM_CH'(1) << wAddr;
        end
        CTL_SPECIAL: begin
          unique case (special_e'(wAddr))
            SP_NOP:       ;
            SP_UPDATE:    stbNext.updAll  = 1'b1;
            SP_BROADCAST: stbNext.loadAll = 1'b1;
            SP_MODE: begin
              stbNext.updAll = 1'b1;
              modeNext       = wData[DATA_W-1];
            end
            default: ;
          endcase
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stb      <= '0;
      modeRise <= 1'b1;
    end else begin
      stb      <= stbNext;
      modeRise <= modeNext;
    end
  end

  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= CNT_W'(WORD_W));
  p_sel_onehot_r4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(stb.chanSel));
  p_act_at_cs_rise_r1: assert property (@(posedge clk) disable iff (!rstN)
    (stb.loadOne || stb.updAll || stb.loadAll) |-> $past(csRise));
  p_sdo_edge_r11: assert property (@(posedge clk) disable iff (!rstN)
    (modeRise && !sckRise) |=> $stable(sdoReg));
endmodule

// File: rtl/qdac_regs.sv
module qdac_regs
  import qdac_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  strobe_t                  stb,
  input  logic                     holdDac,
  output logic [NUM_CH*DATA_W-1:0] dacOut
);
  logic [DATA_W-1:0] inpReg  [NUM_CH];
  logic [DATA_W-1:0] dacReg  [NUM_CH];
  logic [DATA_W-1:0] inpNext [NUM_CH];
  logic [DATA_W-1:0] dacNext [NUM_CH];

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    always_comb begin
      if (stb.loadAll)                         inpNext[ch] = stb.data;
      else if (stb.loadOne && stb.chanSel[ch]) inpNext[ch] = stb.data;
      else                                     inpNext[ch] = inpReg[ch];

      if (!holdDac || stb.updAll || stb.loadAll)    dacNext[ch] = inpNext[ch];
      else if (stb.updOne && stb.chanSel[ch])       dacNext[ch] = inpNext[ch];
      else                                          dacNext[ch] = dacReg[ch];
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        inpReg[ch] <= '0;
        dacReg[ch] <= '0;
      end else begin
        inpReg[ch] <= inpNext[ch];
        dacReg[ch] <= dacNext[ch];
      end
    end

    assign dacOut[ch*DATA_W +: DATA_W] = dacReg[ch];

    p_follow_r9: assert property (@(posedge clk) disable iff (!rstN)
      !holdDac |=> (dacReg[ch] == inpReg[ch]));
    p_hold_stable_r3: assert property (@(posedge clk) disable iff (!rstN)
      (holdDac && !stb.updAll && !stb.loadAll && !(stb.updOne && stb.chanSel[ch]))
        |=> $stable(dacReg[ch]));
    p_broadcast_r7: assert property (@(posedge clk) disable iff (!rstN)
      stb.loadAll |=> (inpReg[ch] == $past(stb.data)) && (dacReg[ch] == $past(stb.data)));
  end
endmodule

// File: rtl/quad_dac_front.sv
module quad_dac_front
  import qdac_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     csN,
  input  logic                     sck,
  input  logic                     sdi,
  input  logic                     holdDac,
  output logic                     sdo,
  output logic [NUM_CH*DATA_W-1:0] dacOut
);
  strobe_t stb;

  qdac_serial_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .csN(csN), .sck(sck), .sdi(sdi),
    .sdo(sdo), .stb(stb)
  );

  qdac_regs regs_i (
    .clk(clk), .rstN(rstN), .stb(stb), .holdDac(holdDac), .dacOut(dacOut)
  );
endmodule

// File: tb/quad_dac_front_tb_top.sv
module quad_dac_front_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1, sck = 1'b0, sdi = 1'b0, holdDac = 1'b1;
  logic sdo;
  logic [47:0] dacOut;
  int errors = 0, checks = 0;
  bit done = 1'b0;
  localparam int HALF = 8;

  always #2 clk = ~clk;

  quad_dac_front dut_i (
    .clk(clk), .rstN(rstN), .csN(csN), .sck(sck), .sdi(sdi),
    .holdDac(holdDac), .sdo(sdo), .dacOut(dacOut)
  );

  typedef struct packed {
    logic        hold;
    logic [15:0] word;
    logic [47:0] exp;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t TBL [NV] = '{
    '{1'b1, 16'h0111, 48'h000_000_000_000},   // R3 load ch0 only
    '{1'b1, 16'h5222, 48'h000_000_222_000},   // R4 load+update ch1
    '{1'b1, 16'h8333, 48'h000_000_222_000},   // R3 load ch2 only
    '{1'b1, 16'hE444, 48'h444_333_222_111},   // R5 load ch3, update all
    '{1'b1, 16'h0555, 48'h444_333_222_111},   // R3
    '{1'b1, 16'h3ABC, 48'h444_333_222_111},   // R6 no-operation
    '{1'b1, 16'h7000, 48'h444_333_222_555},   // R6 update all
    '{1'b1, 16'hB9A5, 48'h9A5_9A5_9A5_9A5},   // R7 load all
    '{1'b1, 16'h0001, 48'h9A5_9A5_9A5_9A5},   // R3
    '{1'b1, 16'h8FFF, 48'h9A5_9A5_9A5_9A5},   // R3
    '{1'b1, 16'hF800, 48'h9A5_FFF_9A5_001},   // R8 mode rising, update all
    '{1'b0, 16'hC777, 48'h777_FFF_9A5_001}    // R9 transparent
  };

  task automatic check(input string req, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic sendBits(input logic [31:0] bits, input int n,
                          output logic [31:0] pre, output logic [31:0] post);
    pre = '0;
    post = '0;
    @(negedge clk) csN = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      sdi = bits[n-1-i];
      repeat (HALF) @(negedge clk);
      pre[n-1-i] = sdo;
      sck = 1'b1;
      repeat (6) @(negedge clk);
      post[n-1-i] = sdo;
      repeat (HALF-6) @(negedge clk);
      sck = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    csN = 1'b1;
    repeat (12) @(negedge clk);
  endtask

  task automatic sendWord(input logic [15:0] w, output logic [15:0] pre, output logic [15:0] post);
    logic [31:0] p, q;
    sendBits({16'h0, w}, 16, p, q);
    pre = p[15:0];
    post = q[15:0];
  endtask

  task automatic summary;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [15:0] pre, post;
    logic [31:0] p32, q32;
    repeat (5) @(negedge clk);
    // R10 reset state
    check("R10 reset dacOut", dacOut, 48'h0);
    check("R10 reset sdo", {47'h0, sdo}, 48'h0);
    rstN = 1'b1;
    repeat (5) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      holdDac = TBL[i].hold;
      sendWord(TBL[i].word, pre, post);
      check($sformatf("R1 vector %0d dacOut", i), dacOut, TBL[i].exp);
      // R11 / R10: rising mode is the default, sdo shows the previous word
      check($sformatf("R11 vector %0d sdo rising", i), {32'h0, post},
            {32'h0, (i == 0) ? 16'h0000 : TBL[i-1].word});
    end

    // R2 short frame ignored
    sendBits({17'h0, 15'h0123}, 15, p32, q32);
    check("R2 short frame", dacOut, 48'h777_FFF_9A5_001);
    // R2 long frame uses last 16 bits
    sendBits({12'h0, 4'hF, 16'h0456}, 20, p32, q32);
    check("R2 long frame", dacOut, 48'h777_FFF_9A5_456);

    // R9 hold then release
    holdDac = 1'b1;
    sendWord(16'h00AA, pre, post);
    check("R3 held load", dacOut, 48'h777_FFF_9A5_456);
    @(negedge clk) holdDac = 1'b0;
    repeat (4) @(negedge clk);
    check("R9 release follows", dacOut, 48'h777_FFF_9A5_0AA);

    // R8 mode falling, with update all
    holdDac = 1'b1;
    sendWord(16'h40BB, pre, post);
    check("R3 held load ch1", dacOut, 48'h777_FFF_9A5_0AA);
    sendWord(16'hF000, pre, post);
    check("R8 mode command updates", dacOut, 48'h777_FFF_0BB_0AA);
    sendWord(16'h3111, pre, post);
    sendWord(16'h3222, pre, post);
    check("R11 falling mode sdo", {32'h0, pre}, {32'h0, 16'h3111});
    check("R6 nop unchanged", dacOut, 48'h777_FFF_0BB_0AA);

    // R10 reset restores rising mode and clears registers
    @(negedge clk) rstN = 1'b0;
    repeat (3) @(negedge clk);
    check("R10 second reset", dacOut, 48'h0);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    sendWord(16'h3AAA, pre, post);
    sendWord(16'h3555, pre, post);
    check("R10 default rising mode", {32'h0, post}, {32'h0, 16'h3AAA});

    done = 1'b1;
    summary();
    $finish;
  end
endmodule